// File: doc/BRIEF.md
# Nonvolatile Index Access Controller

This block sits in front of a small nonvolatile store that is carved into numbered chunks. Each chunk has an allocation record: where it starts, how long it is, which localities may read it, which may write it, whether a matching platform measurement digest or physical presence is needed, and which lock behaviours it carries. Every read or write request is judged in the same cycle it is presented. The block returns grant or deny, a 3-bit reason, and the absolute store address for a granted access. It also updates the per-index lock state on the following clock edge.

Zero-length accesses are commands, not data moves. A zero-length read can close reads until the next power cycle. A zero-length write can close writes until the next power cycle, or for good. Temporal lock state is cleared by a power-cycle pulse. Permanent locks are cleared only by a factory-clear pulse. Records are created through an allocation port. That port refuses to work until an owner exists. An OEM-lock level protects the low, manufacturer-reserved indices from allocation.

Top module: `nvix_guard`

## Requirements
- R1: With no request the outputs are gnt=0, deny=0, why=0 and the access port rejects nothing. A request gets exactly one of gnt/deny. The reason codes, checked in this priority order, are: 1 index not allocated, 2 locality, 3 presence, 4 digest, 5 locked, 6 range, 7 partial write. Code 0 means granted.
- R2: Record mask bit n admits locality n (read mask for reads, write mask for writes). A locality of 5 or above, or one with a cleared bit, is denied with code 2.
- R3: When attribute bit 2 is set and phys_present is low, the request is denied with code 3.
- R4: When attribute bit 0 (reads) or bit 1 (writes) is set and digest_match is low, the request is denied with code 4.
- R5: A non-zero access with off+len greater than the chunk size is denied with code 6. A granted access drives req_addr = base+off.
- R6: When attribute bit 7 is clear, a non-zero write that does not cover exactly offset 0 through the full size is denied with code 7.
- R7: A granted zero-length read on an index with attribute bit 3 set denies every later read of that index with code 5 until a pwr_cycle pulse.
- R8: A granted zero-length write on an index with attribute bit 4 set denies every later write with code 5. This lock survives pwr_cycle and is cleared only by factory_clr.
- R9: A granted zero-length write on an index with attribute bit 5 set denies later writes with code 5 until a pwr_cycle pulse.
- R10: With attribute bit 6 set, the first granted non-zero write in a power cycle makes later non-zero writes deny with code 5 until pwr_cycle. Zero-length writes do not use up this single write.
- R11: Allocation is granted only when owner_set is high and the index is not yet allocated. It is also refused when oem_lock is high and the index is below RSV_CNT. A granted record takes effect for requests from the next cycle.
- R12: When a lock is set in the same cycle as the pulse that would clear it (pwr_cycle or factory_clr), the lock is in force afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears records and locks |
| pwr_cycle | input | 1 | Pulse: clears temporal locks and write-once state |
| factory_clr | input | 1 | Pulse: clears permanent write locks |
| owner_set | input | 1 | Owner established; allocation allowed |
| oem_lock | input | 1 | Freezes the reserved low index range |
| alloc_valid | input | 1 | Allocation request |
| alloc_idx | input | IW | Index to allocate |
| alloc_base | input | LENW | Chunk base address |
| alloc_size | input | LENW | Chunk size |
| alloc_rmask | input | NLOC | Localities allowed to read |
| alloc_wmask | input | NLOC | Localities allowed to write |
| alloc_attr | input | 8 | Attributes: 0 rd digest, 1 wr digest, 2 presence, 3 rd lock, 4 perm wr lock, 5 temp wr lock, 6 write once, 7 partial ok |
| alloc_gnt | output | 1 | Allocation accepted |
| req_valid | input | 1 | Access request |
| req_wr | input | 1 | 1 write, 0 read |
| req_idx | input | IW | Target index |
| req_loc | input | LW | Requesting locality |
| req_off | input | LENW | Offset in chunk |
| req_len | input | LENW | Length; 0 is a lock command |
| digest_match | input | 1 | Current measurement digest matches |
| phys_present | input | 1 | Physical presence asserted |
| req_gnt | output | 1 | Access granted |
| req_deny | output | 1 | Access denied |
| req_why | output | 3 | Reason code |
| req_addr | output | LENW | base+off for the access |

## Verification
The colliding pair is a lock-setting zero-length write and the clearing pulse for that lock in the same cycle. The bench provokes it by raising pwr_cycle together with a zero-length write to a temporally locked index, and factory_clr together with a zero-length write to a permanently locked one. In both cases the verdict is taken from a following full write, which must be denied as locked. Around this, exhaustive sweeps of index, direction, locality, digest, presence and length shape are compared against a priority model in the bench.

// File: rtl/nvix_guard.sv
module nvix_guard #(
  parameter int NIDX    = 4,
  parameter int LENW    = 8,
  parameter int NLOC    = 5,
  parameter int RSV_CNT = 1,
  localparam int IW = $clog2(NIDX),
  localparam int LW = $clog2(NLOC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_cycle,
  input  logic            factory_clr,
  input  logic            owner_set,
  input  logic            oem_lock,
  input  logic            alloc_valid,
  input  logic [IW-1:0]   alloc_idx,
  input  logic [LENW-1:0] alloc_base,
  input  logic [LENW-1:0] alloc_size,
  input  logic [NLOC-1:0] alloc_rmask,
  input  logic [NLOC-1:0] alloc_wmask,
  input  logic [7:0]      alloc_attr,
  output logic            alloc_gnt,
  input  logic            req_valid,
  input  logic            req_wr,
  input  logic [IW-1:0]   req_idx,
  input  logic [LW-1:0]   req_loc,
  input  logic [LENW-1:0] req_off,
  input  logic [LENW-1:0] req_len,
  input  logic            digest_match,
  input  logic            phys_present,
  output logic            req_gnt,
  output logic            req_deny,
  output logic [2:0]      req_why,
  output logic [LENW-1:0] req_addr
);
  localparam logic [IW:0] RSV = RSV_CNT[IW:0];
  localparam logic [LW:0] NL  = NLOC[LW:0];

  logic [NIDX-1:0] used_q, rlk_q, plk_q, wtl_q, wod_q;
  logic [LENW-1:0] base_q [NIDX];
  logic [LENW-1:0] size_q [NIDX];
  logic [NLOC-1:0] rm_q   [NIDX];
  logic [NLOC-1:0] wm_q   [NIDX];
  logic [7:0]      at_q   [NIDX];

  logic [7:0]      at;
  logic [NLOC-1:0] mask;
  logic [LENW:0]   span;
  logic            zero, loc_ok, locked, range_bad, part_bad;
  logic [2:0]      why;

  assign at     = at_q[req_idx];
  assign mask   = req_wr ? wm_q[req_idx] : rm_q[req_idx];
  assign zero   = (req_len == '0);
  assign span   = {1'b0, req_off} + {1'b0, req_len};
  assign loc_ok = ({1'b0, req_loc} < NL) && mask[req_loc];
  assign locked = req_wr ? (plk_q[req_idx] | wtl_q[req_idx] | (wod_q[req_idx] & ~zero))
                         : rlk_q[req_idx];
  assign range_bad = !zero && (span > {1'b0, size_q[req_idx]});
  assign part_bad  = req_wr && !zero && !at[7] &&
                     ((req_off != '0) || (req_len != size_q[req_idx]));

  always_comb begin
    if (!used_q[req_idx])                      why = 3'd1;
    else if (!loc_ok)                          why = 3'd2;
    else if (at[2] && !phys_present)           why = 3'd3;
    else if ((req_wr ? at[1] : at[0]) && !digest_match) why = 3'd4;
    else if (locked)                           why = 3'd5;
    else if (range_bad)                        why = 3'd6;
    else if (part_bad)                         why = 3'd7;
    else                                       why = 3'd0;
  end

  assign req_gnt  = req_valid && (why == 3'd0);
  assign req_deny = req_valid && (why != 3'd0);
  assign req_why  = req_valid ? why : 3'd0;
  assign req_addr = base_q[req_idx] + req_off;

  assign alloc_gnt = alloc_valid && owner_set && !used_q[alloc_idx] &&
                     !(oem_lock && ({1'b0, alloc_idx} < RSV));

  logic [NIDX-1:0] hit, set_rlk, set_plk, set_wtl, set_wod;
  for (genvar i = 0; i < NIDX; i++) begin : g_set
    assign hit[i]     = req_gnt && (req_idx == IW'(i));
    assign set_rlk[i] = hit[i] && !req_wr && zero && at[3];
    assign set_plk[i] = hit[i] && req_wr && zero && at[4];
    assign set_wtl[i] = hit[i] && req_wr && zero && at[5];
    assign set_wod[i] = hit[i] && req_wr && !zero && at[6];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      rlk_q  <= '0;
      plk_q  <= '0;
      wtl_q  <= '0;
      wod_q  <= '0;
      for (int i = 0; i < NIDX; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        rm_q[i]   <= '0;
        wm_q[i]   <= '0;
        at_q[i]   <= '0;
      end
    end else begin
      rlk_q <= (pwr_cycle   ? '0 : rlk_q) | set_rlk;
      wtl_q <= (pwr_cycle   ? '0 : wtl_q) | set_wtl;
      wod_q <= (pwr_cycle   ? '0 : wod_q) | set_wod;
      plk_q <= (factory_clr ? '0 : plk_q) | set_plk;
      if (alloc_gnt) begin
        used_q[alloc_idx] <= 1'b1;
        base_q[alloc_idx] <= alloc_base;
        size_q[alloc_idx] <= alloc_size;
        rm_q[alloc_idx]   <= alloc_rmask;
        wm_q[alloc_idx]   <= alloc_wmask;
        at_q[alloc_idx]   <= alloc_attr;
      end
    end
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_gnt && req_deny) && (req_deny == (req_why != 3'd0)));

  p_loc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_gnt |-> ({1'b0, req_loc} < NL));

  p_rlk_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_gnt && !req_wr && zero && at[3]) |=> rlk_q[$past(req_idx)]);

  p_plk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(factory_clr) |-> ((plk_q & $past(plk_q)) == $past(plk_q)));

  p_tmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_cycle) |-> (((rlk_q & $past(rlk_q)) == $past(rlk_q)) &&
                           ((wtl_q & $past(wtl_q)) == $past(wtl_q)) &&
                           ((wod_q & $past(wod_q)) == $past(wod_q))));

  p_alloc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |=> used_q[$past(alloc_idx)]);

  p_alloc_own_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> owner_set);
endmodule

// File: tb/nvix_guard_tb_top.sv
`timescale 1ns/1ps
module nvix_guard_tb_top;
  logic clk = 0, rst_n = 0;
  logic pwr_cycle = 0, factory_clr = 0, owner_set = 0, oem_lock = 0;
  logic alloc_valid = 0;
  logic [1:0] alloc_idx = 0;
  logic [7:0] alloc_base = 0, alloc_size = 0, alloc_attr = 0;
  logic [4:0] alloc_rmask = 0, alloc_wmask = 0;
  logic alloc_gnt;
  logic req_valid = 0, req_wr = 0, digest_match = 0, phys_present = 0;
  logic [1:0] req_idx = 0;
  logic [2:0] req_loc = 0;
  logic [7:0] req_off = 0, req_len = 0;
  logic req_gnt, req_deny;
  logic [2:0] req_why;
  logic [7:0] req_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int         b_sz[4], b_base[4];
  logic [4:0] b_rm[4], b_wm[4];
  logic [7:0] b_at[4];
  bit b_used[4], m_rlk[4], m_plk[4], m_wtl[4], m_wod[4];

  always #2.5 clk = ~clk;

  nvix_guard dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .factory_clr(factory_clr),
    .owner_set(owner_set), .oem_lock(oem_lock), .alloc_valid(alloc_valid),
    .alloc_idx(alloc_idx), .alloc_base(alloc_base), .alloc_size(alloc_size),
    .alloc_rmask(alloc_rmask), .alloc_wmask(alloc_wmask), .alloc_attr(alloc_attr),
    .alloc_gnt(alloc_gnt), .req_valid(req_valid), .req_wr(req_wr), .req_idx(req_idx),
    .req_loc(req_loc), .req_off(req_off), .req_len(req_len),
    .digest_match(digest_match), .phys_present(phys_present),
    .req_gnt(req_gnt), .req_deny(req_deny), .req_why(req_why), .req_addr(req_addr));

  function automatic int exp_why(int idx, int wr, int loc, int off, int len, int dm, int pp);
    logic [4:0] m;
    logic [7:0] a;
    if (!b_used[idx]) return 1;
    m = wr ? b_wm[idx] : b_rm[idx];
    a = b_at[idx];
    if (loc > 4 || !m[loc]) return 2;
    if (a[2] && pp == 0) return 3;
    if ((wr ? a[1] : a[0]) && dm == 0) return 4;
    if (wr ? (m_plk[idx] || m_wtl[idx] || (m_wod[idx] && len != 0)) : m_rlk[idx]) return 5;
    if (len != 0 && off + len > b_sz[idx]) return 6;
    if (wr && len != 0 && !a[7] && (off != 0 || len != b_sz[idx])) return 7;
    return 0;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic access(string tag, int idx, int wr, int loc, int off, int len,
                        int dm, int pp, int pc = 0, int fc = 0);
    int e;
    @(negedge clk);
    req_valid = 1; req_idx = 2'(idx); req_wr = wr[0]; req_loc = 3'(loc);
    req_off = 8'(off); req_len = 8'(len); digest_match = dm[0]; phys_present = pp[0];
    pwr_cycle = pc[0]; factory_clr = fc[0];
    #1;
    e = exp_why(idx, wr, loc, off, len, dm, pp);
    cmp({tag, " why"}, int'(req_why), e);
    cmp({tag, " gnt"}, int'(req_gnt), e == 0);
    cmp({tag, " deny"}, int'(req_deny), e != 0);
    if (e == 0) cmp({tag, " R5 addr"}, int'(req_addr), (b_base[idx] + off) & 255);
    @(posedge clk);
    #1;
    req_valid = 0; pwr_cycle = 0; factory_clr = 0;
    if (pc != 0) for (int i = 0; i < 4; i++) begin m_rlk[i] = 0; m_wtl[i] = 0; m_wod[i] = 0; end
    if (fc != 0) for (int i = 0; i < 4; i++) m_plk[i] = 0;
    if (e == 0) begin
      if (!wr && len == 0 && b_at[idx][3]) m_rlk[idx] = 1;
      if (wr && len == 0 && b_at[idx][4]) m_plk[idx] = 1;
      if (wr && len == 0 && b_at[idx][5]) m_wtl[idx] = 1;
      if (wr && len != 0 && b_at[idx][6]) m_wod[idx] = 1;
    end
  endtask

  task automatic pulse(int pc, int fc);
    @(negedge clk);
    pwr_cycle = pc[0]; factory_clr = fc[0];
    @(posedge clk);
    #1;
    pwr_cycle = 0; factory_clr = 0;
    if (pc != 0) for (int i = 0; i < 4; i++) begin m_rlk[i] = 0; m_wtl[i] = 0; m_wod[i] = 0; end
    if (fc != 0) for (int i = 0; i < 4; i++) m_plk[i] = 0;
  endtask

  task automatic alloc(int idx, int base, int size, logic [4:0] rm, logic [4:0] wm,
                       logic [7:0] at, int exp);
    @(negedge clk);
    alloc_valid = 1; alloc_idx = 2'(idx); alloc_base = 8'(base); alloc_size = 8'(size);
    alloc_rmask = rm; alloc_wmask = wm; alloc_attr = at;
    #1;
    cmp("R11 alloc_gnt", int'(alloc_gnt), exp);
    @(posedge clk);
    #1;
    alloc_valid = 0;
    if (exp != 0) begin
      b_used[idx] = 1; b_base[idx] = base; b_sz[idx] = size;
      b_rm[idx] = rm; b_wm[idx] = wm; b_at[idx] = at;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int len, off;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    cmp("R1 idle gnt", int'(req_gnt), 0);
    cmp("R1 idle deny", int'(req_deny), 0);
    cmp("R1 idle why", int'(req_why), 0);

    alloc(1, 8, 16, 5'b00101, 5'b00111, 8'h2D, 0);   // R11 no owner
    owner_set = 1;
    oem_lock = 1;
    alloc(0, 0, 8, 5'h1F, 5'h18, 8'h90, 0);           // R11 reserved frozen
    alloc(1, 8, 16, 5'b00101, 5'b00111, 8'h2D, 1);
    alloc(2, 24, 4, 5'h1F, 5'h1F, 8'h42, 1);
    alloc(3, 28, 10, 5'b10000, 5'b01010, 8'h80, 1);
    alloc(1, 40, 4, 5'h1F, 5'h1F, 8'h00, 0);          // R11 already allocated
    access("R1 unallocated", 0, 0, 0, 0, 4, 1, 1);
    oem_lock = 0;
    alloc(0, 0, 8, 5'h1F, 5'h18, 8'h90, 1);

    // R1 R2 R3 R4 R5 R6 R10 sweep
    for (int idx = 0; idx < 4; idx++)
      for (int wr = 0; wr < 2; wr++)
        for (int loc = 0; loc < 8; loc++)
          for (int dm = 0; dm < 2; dm++)
            for (int pp = 0; pp < 2; pp++)
              for (int shp = 0; shp < 3; shp++) begin
                off = (shp == 0) ? 0 : 1;
                len = (shp == 0) ? b_sz[idx] : (shp == 1) ? b_sz[idx] - 1 : b_sz[idx];
                access("R1-sweep R2 R3 R4 R6", idx, wr, loc, off, len, dm, pp);
              end
    pulse(1, 0);

    access("R7 rd lock cmd", 1, 0, 0, 0, 0, 1, 1);
    access("R7 read after lock", 1, 0, 0, 0, 16, 1, 1);
    access("R7 no attr zero rd", 3, 0, 4, 0, 0, 0, 0);
    access("R7 no attr read ok", 3, 0, 4, 0, 10, 0, 0);

    access("R9 wr tlock cmd", 1, 1, 1, 0, 0, 0, 1);
    access("R9 write locked", 1, 1, 1, 0, 16, 0, 1);
    pulse(1, 0);
    access("R9 write after pwr", 1, 1, 1, 0, 16, 0, 1);
    access("R7 read after pwr", 1, 0, 2, 0, 16, 1, 1);

    access("R8 perm lock cmd", 0, 1, 3, 0, 0, 0, 0);
    access("R8 write locked", 0, 1, 4, 0, 8, 0, 0);
    pulse(1, 0);
    access("R8 survives pwr", 0, 1, 4, 0, 8, 0, 0);
    pulse(0, 1);
    access("R8 after factory", 0, 1, 4, 0, 8, 0, 0);

    access("R10 first write", 2, 1, 0, 0, 4, 1, 0);
    access("R10 second write", 2, 1, 0, 0, 4, 1, 0);
    pulse(1, 0);
    access("R10 zero write", 2, 1, 0, 0, 0, 1, 0);
    access("R10 write after zero", 2, 1, 0, 0, 4, 1, 0);
    access("R10 refused again", 2, 1, 0, 0, 4, 1, 0);

    pulse(1, 0);
    access("R12 tlock with pwr", 1, 1, 0, 0, 0, 0, 1, 1, 0);
    access("R12 write after", 1, 1, 0, 0, 16, 0, 1);
    access("R12 plock with fclr", 0, 1, 3, 0, 0, 0, 0, 0, 1);
    access("R12 perm write after", 0, 1, 3, 0, 8, 0, 0);
    pulse(0, 1);
    access("R8 cleared again", 0, 1, 3, 0, 8, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule